// File: doc/BRIEF.md
# Divider-Tapped Programmable Timer

This block is an 8-bit programmable timer driven by a free-running 16-bit divider that advances on every clock. The timer counter does not integrate cycles; it steps once on each falling edge of a single-bit signal. That signal is one divider bit, chosen by a 2-bit select field and ANDed with an enable bit. The counter is compared on every cycle using the current state and the state about to be loaded. As a result, writes that move the divider or change the select or enable can cause an extra count in the same cycle as the write.

When the counter wraps past 0xFF, it does not reload at once. It holds zero for a fixed number of cycles and then takes the modulo value. In that same cycle it raises a one-clock interrupt request. Writes that fall inside this window have defined side effects. Software uses four byte-wide registers through a plain write port and a combinational read port. The write port has no handshake and accepts one write on every cycle that the write strobe is high.

Register addresses: 0 is the divider view, 1 is the counter, 2 is the modulo value and 3 is control. In the control byte, bit 2 is the enable and bits 1:0 are the select.

Top module: `tap_timer`

## Requirements
- R1: The 16-bit divider increments every clock. A read of address 0 returns divider bits 15:8. Any write to address 0 clears the whole divider, whatever the write data.
- R2: The select field picks the tapped divider bit: 01 taps bit 3 (count period 16 clocks), 10 taps bit 5 (64), 11 taps bit 7 (256) and 00 taps bit 9 (1024). With the enable at 0, the counter never steps. A read of address 3 returns 1s in bits 7:3.
- R3: The counter steps by one at the clock edge where the gated tap goes from 1 to 0. The new value is readable in the cycle after that edge.
- R4: A divider clear while the gated tap is 1 steps the counter at the write edge. A clear while it is 0 leaves the counter unchanged.
- R5: A control write steps the counter at the write edge only when the gated tap goes from 1 to 0 because of it. A write that leaves the gated tap at 0, or raises it, adds no step.
- R6: A step from 0xFF makes the counter read 0x00 for exactly 4 cycles, and no steps are taken in that window.
- R7: After those 4 cycles, the counter holds the modulo value for one cycle in which the interrupt request is 1. Outside that cycle the request is 0.
- R8: A counter write during the 4-cycle zero window loads the written value and cancels both the reload and the interrupt.
- R9: A counter write in the cycle where the modulo value was just loaded has no effect.
- R10: A modulo write in that same cycle also loads the written value into the counter.
- R11: After reset, the divider, counter and modulo read 0, the control register reads 0xF8 and the interrupt request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one register per cycle |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 8 | Combinational read data |
| irq | output | 1 | One-cycle interrupt request on reload |

## Verification
The properties assume that reset is held low for at least one edge, and that the write address is always one of the four registers when the strobe is high. They also assume that a write is a single-cycle event judged at the edge. The stimulus changes inputs only on falling clock edges and drops the strobe after exactly one rising edge. Before each timing measurement it also clears the divider with a write, so every expected edge is counted from a known divider value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_RELOADING = 2'd1,
    ST_RELOADED  = 2'd2
  } rld_state_e;

  localparam logic [1:0] A_DIV = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_MOD = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  localparam int CTL_W  = 3;
  localparam int SEL_W  = 2;
  localparam int N_TAPS = 4;
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W = 16,
  parameter int TAP0  = 9,
  parameter int TAP1  = 3,
  parameter int TAP2  = 5,
  parameter int TAP3  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [DIV_W-1:0] div_q,
  output logic [3:0]       tap_cur,
  output logic [3:0]       tap_nxt
);
  localparam int TAPS [4] = '{TAP0, TAP1, TAP2, TAP3};

  logic [DIV_W-1:0] div_nxt;

  always_comb begin
    if (clr) div_nxt = '0;
    else     div_nxt = div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end

  for (genvar i = 0; i < 4; i++) begin : g_tap
    assign tap_cur[i] = div_q[TAPS[i]];
    assign tap_nxt[i] = div_nxt[TAPS[i]];
  end
endmodule

// File: rtl/tmr_tap_sel.sv
module tmr_tap_sel #(
  parameter int SEL_W = 2
) (
  input  logic [(1<<SEL_W)-1:0] taps,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  en,
  output logic                  gated
);
  assign gated = taps[sel] & en;
endmodule

// File: rtl/tmr_ctl_regs.sv
module tmr_ctl_regs #(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctl,
  input  logic              wr_mod,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTL_W-1:0]  ctl_q,
  output logic [CTL_W-1:0]  ctl_nxt,
  output logic [DATA_W-1:0] mod_q
);
  assign ctl_nxt = wr_ctl ? wdata[CTL_W-1:0] : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      mod_q <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      if (wr_mod) mod_q <= wdata;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int RELOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              wr_cnt,
  input  logic              wr_mod,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] mod_q,
  output logic [DATA_W-1:0] cnt_q,
  output rld_state_e        state_q,
  output logic              irq
);
  localparam int WAIT_W = (RELOAD_CYC > 1) ? $clog2(RELOAD_CYC) : 1;
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(RELOAD_CYC - 1);

  logic [DATA_W-1:0] cnt_n;
  rld_state_e        st_n;
  logic [WAIT_W-1:0] wait_q, wait_n;

  always_comb begin
    cnt_n  = cnt_q;
    st_n   = state_q;
    wait_n = wait_q;
    unique case (state_q)
      ST_RUN: begin
        if (wr_cnt) begin
          cnt_n = wdata;
        end else if (step) begin
          if (&cnt_q) begin
            cnt_n  = '0;
            st_n   = ST_RELOADING;
            wait_n = '0;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
      end
      ST_RELOADING: begin
        if (wr_cnt) begin
          cnt_n = wdata;
          st_n  = ST_RUN;
        end else if (wait_q == WAIT_LAST) begin
          cnt_n = mod_q;
          st_n  = ST_RELOADED;
        end else begin
          wait_n = wait_q + 1'b1;
        end
      end
      ST_RELOADED: begin
        st_n = ST_RUN;
        if (wr_mod) cnt_n = wdata;
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      state_q <= ST_RUN;
      wait_q  <= '0;
    end else begin
      cnt_q   <= cnt_n;
      state_q <= st_n;
      wait_q  <= wait_n;
    end
  end

  assign irq = (state_q == ST_RELOADED);
endmodule

// File: rtl/tap_timer.sv
module tap_timer
  import tmr_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int DATA_W     = 8,
  parameter int RELOAD_CYC = 4,
  parameter int TAP0       = 9,
  parameter int TAP1       = 3,
  parameter int TAP2       = 5,
  parameter int TAP3       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  localparam int PAD_W = DATA_W - CTL_W;

  logic [DIV_W-1:0]  div_q;
  logic [3:0]        tap_cur, tap_nxt;
  logic [CTL_W-1:0]  ctl_q, ctl_nxt;
  logic [DATA_W-1:0] mod_q, cnt_q;
  rld_state_e        state_q;
  logic              g_cur, g_nxt, step;
  logic              wr_div, wr_cnt, wr_mod, wr_ctl;

  assign wr_div = wr_en && (wr_addr == A_DIV);
  assign wr_cnt = wr_en && (wr_addr == A_CNT);
  assign wr_mod = wr_en && (wr_addr == A_MOD);
  assign wr_ctl = wr_en && (wr_addr == A_CTL);

  tmr_divider #(.DIV_W(DIV_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(wr_div),
    .div_q(div_q), .tap_cur(tap_cur), .tap_nxt(tap_nxt)
  );

  tmr_ctl_regs #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_mod(wr_mod), .wdata(wr_data),
    .ctl_q(ctl_q), .ctl_nxt(ctl_nxt), .mod_q(mod_q)
  );

  tmr_tap_sel #(.SEL_W(SEL_W)) u_tap_cur (
    .taps(tap_cur), .sel(ctl_q[SEL_W-1:0]), .en(ctl_q[SEL_W]), .gated(g_cur)
  );

  tmr_tap_sel #(.SEL_W(SEL_W)) u_tap_nxt (
    .taps(tap_nxt), .sel(ctl_nxt[SEL_W-1:0]), .en(ctl_nxt[SEL_W]), .gated(g_nxt)
  );

  assign step = g_cur & ~g_nxt;

  tmr_counter #(.DATA_W(DATA_W), .RELOAD_CYC(RELOAD_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_cnt(wr_cnt), .wr_mod(wr_mod),
    .wdata(wr_data), .mod_q(mod_q), .cnt_q(cnt_q), .state_q(state_q), .irq(irq)
  );

  always_comb begin
    unique case (rd_addr)
      A_DIV:   rd_data = div_q[DIV_W-1 -: DATA_W];
      A_CNT:   rd_data = cnt_q;
      A_MOD:   rd_data = mod_q;
      default: rd_data = {{PAD_W{1'b1}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/tap_timer_chk.sv
module tap_timer_chk
  import tmr_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [DIV_W-1:0]  div_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input rld_state_e        state_q,
  input logic              irq
);
  // R1
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_DIV) |=> (div_q == '0));

  // R1
  div_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_DIV) |=> (div_q == $past(div_q) + 1'b1));

  // R6
  zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELOADING) |-> (cnt_q == '0));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7
  irq_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cnt_q == mod_q));

  // R8
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RELOADING && wr_en && wr_addr == A_CNT) |=> (!irq && state_q == ST_RUN));
endmodule

bind tap_timer tap_timer_chk #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .div_q(div_q),
  .cnt_q(cnt_q), .mod_q(mod_q), .state_q(state_q), .irq(irq)
);

// File: tb/tb_tap_timer.sv
`timescale 1ns/1ps
module tb_tap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [1:0] DIV = 2'd0, CNT = 2'd1, MOD = 2'd2, CTL = 2'd3;

  tap_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic rchk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // caller stands at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic test_reset();
    rchk("R11 div", DIV, 8'h00);
    rchk("R11 cnt", CNT, 8'h00);
    rchk("R11 mod", MOD, 8'h00);
    rchk("R11 ctl", CTL, 8'hF8);
    chk("R11 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic test_div_read();
    wr(DIV, 8'hA5);
    repeat (299) @(negedge clk);
    rchk("R1 div bits 15:8 after 299", DIV, 8'h01);
    wr(DIV, 8'h3C);
    rchk("R1 div cleared", DIV, 8'h00);
  endtask

  task automatic test_period(input logic [1:0] sel, input int n, input string req);
    wr(CTL, {5'd0, 1'b1, sel});
    wr(DIV, 8'h00);
    wr(CNT, 8'h00);
    repeat (n - 2) @(negedge clk);
    rchk({req, " before first fall"}, CNT, 8'h00);
    @(negedge clk);
    rchk({req, " R3 first fall"}, CNT, 8'h01);
    repeat (n - 1) @(negedge clk);
    rchk({req, " before second fall"}, CNT, 8'h01);
    @(negedge clk);
    rchk({req, " R3 second fall"}, CNT, 8'h02);
  endtask

  task automatic test_disabled();
    wr(CTL, 8'h01);
    wr(DIV, 8'h00);
    wr(CNT, 8'h03);
    repeat (40) @(negedge clk);
    rchk("R2 enable off", CNT, 8'h03);
    wr(CTL, 8'h05);
    rchk("R2 ctl readback", CTL, 8'hFD);
  endtask

  task automatic test_div_glitch();
    wr(CTL, 8'h05);
    wr(DIV, 8'h00);
    wr(CNT, 8'h05);
    repeat (7) @(negedge clk);          // divider now 8, tapped bit 3 high
    wr(DIV, 8'h00);
    rchk("R4 clear with tap high", CNT, 8'h06);
    wr(DIV, 8'h00);                     // divider was 0, tap low
    rchk("R4 clear with tap low", CNT, 8'h06);
  endtask

  task automatic test_ctl_glitch();
    wr(CTL, 8'h05);
    wr(DIV, 8'h00);
    wr(CNT, 8'h0A);
    repeat (7) @(negedge clk);          // divider 8
    wr(CTL, 8'h01);                     // enable drops while tap high
    rchk("R5 disable falls", CNT, 8'h0B);
    wr(CTL, 8'h05);                     // gated signal rises
    rchk("R5 rise no step", CNT, 8'h0B);
    wr(CTL, 8'h06);                     // bit3 high -> bit5 low
    rchk("R5 select change falls", CNT, 8'h0C);
  endtask

  task automatic reload_setup();
    wr(MOD, 8'h40);
    wr(CTL, 8'h05);
    wr(DIV, 8'h00);
    wr(CNT, 8'hFF);
    repeat (15) @(negedge clk);         // just after the wrapping edge
  endtask

  task automatic test_reload();
    reload_setup();
    rchk("R6 zero window 1", CNT, 8'h00);
    chk("R7 irq low in window", {7'd0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    rchk("R6 zero window 4", CNT, 8'h00);
    chk("R7 irq low at window end", {7'd0, irq}, 8'h00);
    @(negedge clk);
    rchk("R7 loaded modulo", CNT, 8'h40);
    chk("R7 irq pulse", {7'd0, irq}, 8'h01);
    @(negedge clk);
    chk("R7 irq single cycle", {7'd0, irq}, 8'h00);
    rchk("R7 value held", CNT, 8'h40);
  endtask

  task automatic test_cancel();
    logic seen;
    seen = 1'b0;
    reload_setup();
    wr(CNT, 8'h22);
    for (int i = 0; i < 5; i++) begin
      if (irq) seen = 1'b1;
      @(negedge clk);
    end
    chk("R8 irq cancelled", {7'd0, seen}, 8'h00);
    rchk("R8 written value kept", CNT, 8'h22);
  endtask

  task automatic test_ignore();
    reload_setup();
    repeat (4) @(negedge clk);
    chk("R9 in loaded cycle", {7'd0, irq}, 8'h01);
    wr(CNT, 8'h77);
    rchk("R9 counter write ignored", CNT, 8'h40);
  endtask

  task automatic test_mod_copy();
    reload_setup();
    repeat (4) @(negedge clk);
    wr(MOD, 8'h55);
    rchk("R10 counter takes write", CNT, 8'h55);
    rchk("R10 modulo stored", MOD, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_div_read();
    test_period(2'b01, 16,   "R2 sel01");
    test_period(2'b10, 64,   "R2 sel10");
    test_period(2'b11, 256,  "R2 sel11");
    test_period(2'b00, 1024, "R2 sel00");
    test_disabled();
    test_div_glitch();
    test_ctl_glitch();
    test_reload();
    test_cancel();
    test_ignore();
    test_mod_copy();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule